// File: doc/BRIEF.md
# Register-Indirect Effective Address Generator

This block forms the source and destination effective addresses for a data-move operation in a 16-bit processor that has sixteen working registers. Each operand has its own addressing mode and its own base register. Both operands draw on one shared offset-register number and on one short literal. The surrounding pipeline reads the register file with the numbers it presents. It hands the base values and the offset value to the block together with a valid strobe. One cycle later the block returns both addresses. It also returns up to two pointer write-back requests, which the register file applies at the following clock edge.

The modes are these. Plain indirect uses the base as the address. Post-modify uses the base as the address and then steps the pointer. Pre-modify steps the pointer first and uses the stepped value. Indexed adds the offset register to the base. Literal-offset adds a sign-extended literal to the base. All address arithmetic is 16 bits wide and wraps. When both operands update the same pointer, only the destination update is issued.

Top module: `ea_gen`

## Requirements
- R1: While reset is low and on the first cycle after it, `valid_o`, `wb_src_en` and `wb_dst_en` are 0 and both addresses read 0.
- R2: Mode code 0 (indirect) gives an address equal to the base register value and requests no write-back.
- R3: Mode code 1 (post-modify) gives an address equal to the unmodified base. It requests a write-back of the stepped base to the same register number.
- R4: Mode code 2 (pre-modify) gives the stepped base as the address. It requests a write-back of that same value to the base register.
- R5: The step is 1 when `byte_op` is 1 and 2 when it is 0. The operand's direction bit (`src_dec`/`dst_dec`) set to 1 subtracts the step; set to 0 it adds the step.
- R6: Mode code 3 (indexed) gives base plus the value of the shared offset register. It requests no write-back.
- R7: Mode code 4 (literal offset) gives base plus the 10-bit `lit`, which is sign-extended from bit 9. It requests no write-back.
- R8: Every sum and step is taken modulo 2^16 (for example 0xFFFF plus 2 gives 0x0001, and 0x0000 minus 1 gives 0xFFFF).
- R9: Source and destination modes are chosen independently, and both use the single shared offset-register value in indexed mode.
- R10: When both operands request a write-back to the same register number, `wb_src_en` stays 0 and the destination write-back is issued alone.
- R11: Outputs update on the clock edge that samples `valid_i`=1, and `valid_o` is 1 for that one cycle. In a cycle without `valid_i`, both write-back enables fall to 0 and both addresses hold their last values.
- R12: Mode codes 5 to 7 behave as plain indirect: the address is the base and there is no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operand fields and register values are valid this cycle |
| src_mode | input | 3 | Source addressing mode code |
| dst_mode | input | 3 | Destination addressing mode code |
| src_reg | input | 4 | Source base register number |
| dst_reg | input | 4 | Destination base register number |
| ofs_reg | input | 4 | Shared offset register number (read by the harness) |
| src_val | input | 16 | Contents of the source base register |
| dst_val | input | 16 | Contents of the destination base register |
| ofs_val | input | 16 | Contents of the shared offset register |
| lit | input | 10 | Signed literal offset |
| byte_op | input | 1 | 1 = byte operation (step 1), 0 = word (step 2) |
| src_dec | input | 1 | Source pointer step direction, 1 = decrement |
| dst_dec | input | 1 | Destination pointer step direction, 1 = decrement |
| valid_o | output | 1 | Registered results valid |
| src_ea | output | 16 | Source effective address |
| dst_ea | output | 16 | Destination effective address |
| wb_src_en | output | 1 | Source pointer write-back request |
| wb_src_idx | output | 4 | Source write-back register number |
| wb_src_data | output | 16 | Source write-back value |
| wb_dst_en | output | 1 | Destination pointer write-back request |
| wb_dst_idx | output | 4 | Destination write-back register number |
| wb_dst_data | output | 16 | Destination write-back value |

## Verification
The sweep pairs every source mode code with every destination mode code, both sizes and all four direction combinations. This shows that each operand's mode, step and direction act alone and are not borrowed from the other operand. Base values of 0x0000 and 0xFFFF in some patterns expose carry and borrow handling that a wider or non-wrapping adder would get wrong. Register numbers are derived so that the two base registers sometimes coincide, which separates correct conflict resolution from a plain pass-through of both requests. An idle cycle after each operation checks the dropped enables, the held addresses and the pointer values that land in the register file.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW = 16,
  parameter int RN = 16,
  parameter int LW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [2:0]        src_mode,
  input  logic [2:0]        dst_mode,
  input  logic [$clog2(RN)-1:0] src_reg,
  input  logic [$clog2(RN)-1:0] dst_reg,
  input  logic [$clog2(RN)-1:0] ofs_reg,
  input  logic [AW-1:0]     src_val,
  input  logic [AW-1:0]     dst_val,
  input  logic [AW-1:0]     ofs_val,
  input  logic [LW-1:0]     lit,
  input  logic              byte_op,
  input  logic              src_dec,
  input  logic              dst_dec,
  output logic              valid_o,
  output logic [AW-1:0]     src_ea,
  output logic [AW-1:0]     dst_ea,
  output logic              wb_src_en,
  output logic [$clog2(RN)-1:0] wb_src_idx,
  output logic [AW-1:0]     wb_src_data,
  output logic              wb_dst_en,
  output logic [$clog2(RN)-1:0] wb_dst_idx,
  output logic [AW-1:0]     wb_dst_data
);
  localparam int RIW = $clog2(RN);
  localparam int RW  = 2*AW + 1;
  localparam logic [2:0] M_POST = 3'd1;
  localparam logic [2:0] M_PRE  = 3'd2;
  localparam logic [2:0] M_IDX  = 3'd3;
  localparam logic [2:0] M_LIT  = 3'd4;

  function automatic logic [RW-1:0] eval_op(
    input logic [2:0]    m,
    input logic [AW-1:0] base,
    input logic          dec,
    input logic [AW-1:0] stp,
    input logic [AW-1:0] ofs,
    input logic [AW-1:0] lx
  );
    logic [AW-1:0] nv;
    nv = dec ? base - stp : base + stp;
    case (m)
      M_POST:  return {1'b1, base, nv};
      M_PRE:   return {1'b1, nv, nv};
      M_IDX:   return {1'b0, base + ofs, nv};
      M_LIT:   return {1'b0, base + lx, nv};
      default: return {1'b0, base, nv};
    endcase
  endfunction

  logic [AW-1:0] step, lit_x;
  logic [RW-1:0] s_r, d_r;
  logic          clash;

  assign step  = byte_op ? AW'(1) : AW'(2);
  assign lit_x = {{(AW-LW){lit[LW-1]}}, lit};
  assign s_r   = eval_op(src_mode, src_val, src_dec, step, ofs_val, lit_x);
  assign d_r   = eval_op(dst_mode, dst_val, dst_dec, step, ofs_val, lit_x);
  assign clash = s_r[RW-1] && d_r[RW-1] && (src_reg == dst_reg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o     <= 1'b0;
      src_ea      <= '0;
      dst_ea      <= '0;
      wb_src_en   <= 1'b0;
      wb_dst_en   <= 1'b0;
      wb_src_idx  <= '0;
      wb_dst_idx  <= '0;
      wb_src_data <= '0;
      wb_dst_data <= '0;
    end else begin
      valid_o   <= valid_i;
      wb_src_en <= valid_i && s_r[RW-1] && !clash;
      wb_dst_en <= valid_i && d_r[RW-1];
      if (valid_i) begin
        src_ea      <= s_r[2*AW-1:AW];
        dst_ea      <= d_r[2*AW-1:AW];
        wb_src_idx  <= src_reg;
        wb_dst_idx  <= dst_reg;
        wb_src_data <= s_r[AW-1:0];
        wb_dst_data <= d_r[AW-1:0];
      end
    end
  end

  logic unused_ok;
  assign unused_ok = ^ofs_reg;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW = 16,
  parameter int RN = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_i,
  input logic [2:0]        src_mode,
  input logic [2:0]        dst_mode,
  input logic [$clog2(RN)-1:0] src_reg,
  input logic [$clog2(RN)-1:0] dst_reg,
  input logic [AW-1:0]     src_val,
  input logic [AW-1:0]     ofs_val,
  input logic              valid_o,
  input logic [AW-1:0]     src_ea,
  input logic [AW-1:0]     dst_ea,
  input logic              wb_src_en,
  input logic [$clog2(RN)-1:0] wb_src_idx,
  input logic              wb_dst_en,
  input logic [$clog2(RN)-1:0] wb_dst_idx,
  input logic [AW-1:0]     wb_dst_data
);
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n) valid_i |=> valid_o); // R11
  AST_WB_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) (wb_src_en || wb_dst_en) |-> valid_o); // R11
  AST_NO_DOUBLE_WB: assert property (@(posedge clk) disable iff (!rst_n) (wb_src_en && wb_dst_en) |-> (wb_src_idx != wb_dst_idx)); // R10
  AST_DST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(src_mode) == 3'd1 && $past(dst_mode) == 3'd1 && $past(src_reg) == $past(dst_reg))
    |-> (!wb_src_en && wb_dst_en)); // R10
  AST_POST_EA: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(src_mode) == 3'd1) |-> (src_ea == $past(src_val))); // R3
  AST_PRE_EA: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(dst_mode) == 3'd2) |-> (wb_dst_en && dst_ea == wb_dst_data)); // R4
  AST_IDX_EA: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(src_mode) == 3'd3) |-> (src_ea == AW'($past(src_val) + $past(ofs_val)) && !wb_src_en)); // R6
  AST_SPARE_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(src_mode) >= 3'd5) |-> (!wb_src_en && src_ea == $past(src_val))); // R12
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(src_ea) && $stable(dst_ea))); // R11
endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .RN(RN)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
  .src_mode(src_mode), .dst_mode(dst_mode),
  .src_reg(src_reg), .dst_reg(dst_reg),
  .src_val(src_val), .ofs_val(ofs_val),
  .valid_o(valid_o), .src_ea(src_ea), .dst_ea(dst_ea),
  .wb_src_en(wb_src_en), .wb_src_idx(wb_src_idx),
  .wb_dst_en(wb_dst_en), .wb_dst_idx(wb_dst_idx),
  .wb_dst_data(wb_dst_data)
);

// File: tb/sim_ea_gen.sv
`timescale 1ns/1ps
module sim_ea_gen;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, valid_i, byte_op, src_dec, dst_dec;
  logic [2:0]  src_mode, dst_mode;
  logic [3:0]  src_reg, dst_reg, ofs_reg;
  logic [9:0]  lit;
  logic        valid_o, wb_src_en, wb_dst_en;
  logic [15:0] src_ea, dst_ea, wb_src_data, wb_dst_data;
  logic [3:0]  wb_src_idx, wb_dst_idx;
  logic [15:0] rf [16];
  logic [15:0] src_val, dst_val, ofs_val;

  assign src_val = rf[src_reg];
  assign dst_val = rf[dst_reg];
  assign ofs_val = rf[ofs_reg];

  always @(posedge clk) begin
    if (wb_src_en) rf[wb_src_idx] <= wb_src_data;
    if (wb_dst_en) rf[wb_dst_idx] <= wb_dst_data;
  end

  ea_gen u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
    .src_mode(src_mode), .dst_mode(dst_mode),
    .src_reg(src_reg), .dst_reg(dst_reg), .ofs_reg(ofs_reg),
    .src_val(src_val), .dst_val(dst_val), .ofs_val(ofs_val),
    .lit(lit), .byte_op(byte_op), .src_dec(src_dec), .dst_dec(dst_dec),
    .valid_o(valid_o), .src_ea(src_ea), .dst_ea(dst_ea),
    .wb_src_en(wb_src_en), .wb_src_idx(wb_src_idx), .wb_src_data(wb_src_data),
    .wb_dst_en(wb_dst_en), .wb_dst_idx(wb_dst_idx), .wb_dst_data(wb_dst_data)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // model: {write, ea, new pointer}
  function automatic logic [32:0] model(input logic [2:0] m, input logic [15:0] b,
      input logic dec, input logic bop, input logic [15:0] o, input logic [9:0] l);
    logic [15:0] st, nv, lx;
    st = bop ? 16'd1 : 16'd2;
    nv = dec ? 16'(b - st) : 16'(b + st);
    lx = 16'($signed(l));
    case (m)
      3'd1: return {1'b1, b, nv};
      3'd2: return {1'b1, nv, nv};
      3'd3: return {1'b0, 16'(b + o), nv};
      3'd4: return {1'b0, 16'(b + lx), nv};
      default: return {1'b0, b, nv};
    endcase
  endfunction

  function automatic string tag(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3/R5";
      3'd2: return "R4/R5";
      3'd3: return "R6/R9";
      3'd4: return "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'd0, 16'd1);
    summary();
  end

  initial begin
    logic [32:0] es, ed;
    logic [15:0] sv, dv, ov, held_s, held_d;
    bit same, wrap;
    int n;
    n = 0;
    for (int k = 0; k < 16; k++) rf[k] = 16'(k * 16'h1111);
    rst_n = 1'b0; valid_i = 1'b0; src_mode = '0; dst_mode = '0;
    src_reg = '0; dst_reg = '0; ofs_reg = '0; lit = '0;
    byte_op = 1'b0; src_dec = 1'b0; dst_dec = 1'b0;
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0 && wb_src_en == 1'b0 && wb_dst_en == 1'b0, "R1", "flags in reset",
        {13'd0, valid_o, wb_src_en, wb_dst_en}, 16'd0);
    chk(src_ea == 16'd0 && dst_ea == 16'd0, "R1", "addresses in reset", src_ea | dst_ea, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid_o == 1'b0 && wb_src_en == 1'b0 && wb_dst_en == 1'b0, "R1", "flags after reset",
        {13'd0, valid_o, wb_src_en, wb_dst_en}, 16'd0);

    for (int sm = 0; sm < 8; sm++)
      for (int dm = 0; dm < 8; dm++)
        for (int b = 0; b < 2; b++)
          for (int d = 0; d < 4; d++) begin
            n++;
            src_mode = 3'(sm); dst_mode = 3'(dm);
            byte_op = b[0]; src_dec = d[0]; dst_dec = d[1];
            src_reg = 4'(sm * 3 + d);
            dst_reg = 4'(dm * 5 + b + d);
            ofs_reg = 4'(sm + dm + 7);
            lit = (n % 7 == 0) ? 10'h200 : 10'(n * 37);
            wrap = (n % 3 == 0);
            rf[ofs_reg] = 16'(n * 16'h2B1 + 16'h8000);
            rf[src_reg] = wrap ? (d[0] ? 16'h0000 : 16'hFFFF) : 16'(n * 16'h3A7);
            rf[dst_reg] = wrap ? (d[1] ? 16'h0000 : 16'hFFFF) : 16'(n * 16'h5C3 + 16'hF000);
            sv = src_val; dv = dst_val; ov = ofs_val;
            es = model(3'(sm), sv, d[0], b[0], ov, lit);
            ed = model(3'(dm), dv, d[1], b[0], ov, lit);
            same = es[32] && ed[32] && (src_reg == dst_reg);
            valid_i = 1'b1;
            @(negedge clk);
            valid_i = 1'b0;
            chk(valid_o == 1'b1, "R11", "valid_o one cycle after strobe", {15'd0, valid_o}, 16'd1);
            chk(src_ea == es[31:16], wrap ? "R8" : tag(3'(sm)), "src_ea", src_ea, es[31:16]);
            chk(dst_ea == ed[31:16], wrap ? "R8" : tag(3'(dm)), "dst_ea", dst_ea, ed[31:16]);
            chk(wb_src_en == (es[32] && !same), same ? "R10" : tag(3'(sm)), "wb_src_en",
                {15'd0, wb_src_en}, {15'd0, es[32] && !same});
            chk(wb_dst_en == ed[32], tag(3'(dm)), "wb_dst_en", {15'd0, wb_dst_en}, {15'd0, ed[32]});
            if (es[32] && !same)
              chk(wb_src_idx == src_reg && wb_src_data == es[15:0], "R5", "src write-back",
                  wb_src_data, es[15:0]);
            if (ed[32])
              chk(wb_dst_idx == dst_reg && wb_dst_data == ed[15:0], "R5", "dst write-back",
                  wb_dst_data, ed[15:0]);
            held_s = src_ea; held_d = dst_ea;
            @(negedge clk);
            chk(valid_o == 1'b0 && wb_src_en == 1'b0 && wb_dst_en == 1'b0, "R11", "idle flags",
                {13'd0, valid_o, wb_src_en, wb_dst_en}, 16'd0);
            chk(src_ea == held_s && dst_ea == held_d, "R11", "idle hold", src_ea, held_s);
            if (ed[32])
              chk(rf[dst_reg] == ed[15:0], same ? "R10" : "R5", "dst pointer in file",
                  rf[dst_reg], ed[15:0]);
            if (es[32] && !same)
              chk(rf[src_reg] == es[15:0], "R5", "src pointer in file", rf[src_reg], es[15:0]);
          end
    summary();
  end
endmodule